// File: doc/BRIEF.md
# Pipelined Instruction Fetch Front End with Branch Squash

This block is the front end of a five-stage, 32-bit in-order pipeline. It holds the program counter and presents it to an instruction memory port that answers combinationally. It then moves each fetched word, together with the address of the word after it (PC+4), through two pipeline registers. The first sits between fetch and decode, the second between decode and execute. The second register's contents are the block's outputs to the later stages: a valid bit, PC+4, the raw instruction word, the sign-extended immediate and two write-enable control bits.

Control transfers are handled inside the block. An unconditional jump is recognised in decode and redirects fetch immediately, which costs one slot. A conditional branch is resolved once it sits in the execute register, using a zero/compare flag from the external ALU, and a taken branch costs two slots. Any instruction fetched down the wrong path becomes a bubble: its valid bit is cleared and its write enables are forced low, so it can never alter architectural state.

Top module: `fetch_front`

## Requirements
- R1: A synchronous reset puts the fetch address at the `RESET_VEC` parameter (default 0x00400000) and clears the valid bit and both write enables of the execute-side register.
- R2: With no redirect, the fetch address rises by 4 every cycle. The word fetched at address A appears two cycles later at the execute outputs, with `exPc4` = A+4 and `exInstr` equal to that word.
- R3: `exImm` is bits 15:0 of `exInstr`, sign-extended to 32 bits.
- R4: A valid instruction in decode whose bits 31:26 are 000010 is a jump. The next fetch address is PC+4 bits 31:28, then instruction bits 25:0, then two zero bits. Only the one word fetched behind the jump is squashed, and the jump itself moves on to execute.
- R5: A valid instruction in execute with opcode 000100 is taken when `brZero` is 1, and one with opcode 000101 is taken when `brZero` is 0. On a taken branch the next fetch address is `exPc4` + (`exImm` shifted left by 2), and both younger instructions (those in decode and fetch) become bubbles.
- R6: A bubble at the execute outputs has `exValid` = 0, `exRegWrite` = 0 and `exMemWrite` = 0.
- R7: For a valid entry, `exRegWrite` is 1 exactly for opcodes 000000 and 100011, and `exMemWrite` is 1 exactly for opcode 101011.
- R8: When a taken branch in execute and a jump in decode occur in the same cycle, the branch target is fetched next and the jump is discarded.
- R9: `brZero` has no effect unless the execute entry is a valid branch: the fetch sequence then continues as R2 and R4 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 32 | Fetch address (current PC) |
| imemData | input | 32 | Instruction word at `imemAddr`, same cycle |
| brZero | input | 1 | Zero/compare flag for the branch now in execute |
| exValid | output | 1 | Execute-side entry holds a real instruction |
| exPc4 | output | 32 | PC+4 of the execute-side instruction |
| exInstr | output | 32 | Execute-side instruction word |
| exImm | output | 32 | Sign-extended immediate of that instruction |
| exRegWrite | output | 1 | Register-file write enable, low for bubbles |
| exMemWrite | output | 1 | Data-memory write enable, low for bubbles |

## Verification
The hardest case to reach is a taken branch in execute while the very next word, now in decode, is a jump. Here the older branch must win and the jump must vanish. A directed program places a branch followed immediately by a jump and runs it once with the flag forcing the branch taken and once forcing it not taken, so both sides of the priority are seen. Random programs dense in branches, jumps and negative offsets then drive the flag randomly on every cycle. This also covers flag activity while no branch is present, and squashes that land on entries that are already bubbles.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int XLEN        = 32;
  localparam int OP_W        = 6;
  localparam int IMM_W       = 16;
  localparam int JIDX_W      = 26;
  localparam int PCHI_W      = XLEN - JIDX_W - 2;
  localparam int WORD_SHIFT  = 2;
  localparam int INSTR_BYTES = 4;

  typedef enum logic [OP_W-1:0] {
    OP_RTYPE = 6'b000000,
    OP_JUMP  = 6'b000010,
    OP_BEQ   = 6'b000100,
    OP_BNE   = 6'b000101,
    OP_LOAD  = 6'b100011,
    OP_STORE = 6'b101011
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeBranch;
    logic takeJump;
    logic squashIfId;
    logic squashIdEx;
  } fetchCtl_t;

  typedef struct packed {
    logic            valid;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] instr;
  } ifId_t;

  typedef struct packed {
    logic            valid;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] imm;
    logic            regWr;
    logic            memWr;
  } idEx_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic            idValid,
  input  logic [OP_W-1:0] idOpcode,
  input  logic            exValid,
  input  logic [OP_W-1:0] exOpcode,
  input  logic            brZero,
  output fetchCtl_t       ctl
);
  logic exIsBranch;
  logic condMet;
  logic idIsJump;

  always_comb begin
    exIsBranch = exValid && ((exOpcode == OP_BEQ) || (exOpcode == OP_BNE));
    // beq wants a zero result, bne a nonzero one
    condMet    = (exOpcode == OP_BNE) ? !brZero : brZero;
    idIsJump   = idValid && (idOpcode == OP_JUMP);

    ctl.takeBranch = exIsBranch && condMet;
    // the older instruction in EX has priority over the jump in ID
    ctl.takeJump   = idIsJump && !ctl.takeBranch;
    ctl.squashIfId = ctl.takeBranch || ctl.takeJump;
    ctl.squashIdEx = ctl.takeBranch;
  end
endmodule

// File: rtl/fetch_dpath.sv
module fetch_dpath
  import fetch_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  fetchCtl_t       ctl,
  input  logic [XLEN-1:0] imemData,
  output logic [XLEN-1:0] imemAddr,
  output logic            idValid,
  output logic [OP_W-1:0] idOpcode,
  output logic            exValid,
  output logic [XLEN-1:0] exPc4,
  output logic [XLEN-1:0] exInstr,
  output logic [XLEN-1:0] exImm,
  output logic            exRegWrite,
  output logic            exMemWrite
);
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] pcPlus4;
  logic [XLEN-1:0] nextPc;
  logic [XLEN-1:0] idImm;
  logic [XLEN-1:0] jTarget;
  logic [XLEN-1:0] brTarget;
  logic [OP_W-1:0] idOp;
  ifId_t           ifid;
  ifId_t           ifidNext;
  idEx_t           idex;
  idEx_t           idexNext;

  // IF: sequential address
  assign pcPlus4 = pc + XLEN'(INSTR_BYTES);

  // ID: decode, sign extension, jump target (no adder)
  assign idOp    = ifid.instr[XLEN-1 -: OP_W];
  assign idImm   = {{(XLEN-IMM_W){ifid.instr[IMM_W-1]}}, ifid.instr[IMM_W-1:0]};
  assign jTarget = {ifid.pc4[XLEN-1 -: PCHI_W], ifid.instr[JIDX_W-1:0],
                    {WORD_SHIFT{1'b0}}};

  // EX: word offset scaled and added to PC+4
  assign brTarget = idex.pc4 + (idex.imm << WORD_SHIFT);

  always_comb begin
    if (ctl.takeBranch)    nextPc = brTarget;
    else if (ctl.takeJump) nextPc = jTarget;
    else                   nextPc = pcPlus4;
  end

  always_comb begin
    ifidNext = '0;
    if (!ctl.squashIfId) begin
      ifidNext.valid = 1'b1;
      ifidNext.pc4   = pcPlus4;
      ifidNext.instr = imemData;
    end
  end

  always_comb begin
    idexNext = '0;
    if (!ctl.squashIdEx && ifid.valid) begin
      idexNext.valid = 1'b1;
      idexNext.pc4   = ifid.pc4;
      idexNext.instr = ifid.instr;
      idexNext.imm   = idImm;
      idexNext.regWr = (idOp == OP_RTYPE) || (idOp == OP_LOAD);
      idexNext.memWr = (idOp == OP_STORE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= RESET_VEC;
      ifid <= '0;
      idex <= '0;
    end else begin
      pc   <= nextPc;
      ifid <= ifidNext;
      idex <= idexNext;
    end
  end

  assign imemAddr   = pc;
  assign idValid    = ifid.valid;
  assign idOpcode   = idOp;
  assign exValid    = idex.valid;
  assign exPc4      = idex.pc4;
  assign exInstr    = idex.instr;
  assign exImm      = idex.imm;
  assign exRegWrite = idex.regWr;
  assign exMemWrite = idex.memWr;
endmodule

// File: rtl/fetch_front.sv
module fetch_front
  import fetch_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imemAddr,
  input  logic [XLEN-1:0] imemData,
  input  logic            brZero,
  output logic            exValid,
  output logic [XLEN-1:0] exPc4,
  output logic [XLEN-1:0] exInstr,
  output logic [XLEN-1:0] exImm,
  output logic            exRegWrite,
  output logic            exMemWrite
);
  fetchCtl_t       ctl;
  logic            idValid;
  logic [OP_W-1:0] idOpcode;
  logic [OP_W-1:0] exOpcode;

  assign exOpcode = exInstr[XLEN-1 -: OP_W];

  fetch_ctrl u_ctrl (
    .idValid  (idValid),
    .idOpcode (idOpcode),
    .exValid  (exValid),
    .exOpcode (exOpcode),
    .brZero   (brZero),
    .ctl      (ctl)
  );

  fetch_dpath #(.RESET_VEC(RESET_VEC)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .imemData   (imemData),
    .imemAddr   (imemAddr),
    .idValid    (idValid),
    .idOpcode   (idOpcode),
    .exValid    (exValid),
    .exPc4      (exPc4),
    .exInstr    (exInstr),
    .exImm      (exImm),
    .exRegWrite (exRegWrite),
    .exMemWrite (exMemWrite)
  );
endmodule

// File: rtl/fetch_front_chk.sv
module fetch_front_chk
  import fetch_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imemAddr,
  input logic            brZero,
  input logic            exValid,
  input logic [XLEN-1:0] exPc4,
  input logic [XLEN-1:0] exInstr,
  input logic [XLEN-1:0] exImm,
  input logic            exRegWrite,
  input logic            exMemWrite
);
  logic [OP_W-1:0] op;
  logic            beqTaken;
  logic            bneTaken;

  assign op       = exInstr[XLEN-1 -: OP_W];
  assign beqTaken = exValid && (op == OP_BEQ) && brZero;
  assign bneTaken = exValid && (op == OP_BNE) && !brZero;

  a_r1_reset_vector: assert property (@(posedge clk)
    rst |=> (imemAddr == RESET_VEC) && !exValid && !exRegWrite && !exMemWrite);

  a_r6_bubble_quiet: assert property (@(posedge clk) disable iff (rst)
    !exValid |-> (!exRegWrite && !exMemWrite));

  a_r5_beq_redirect: assert property (@(posedge clk) disable iff (rst)
    beqTaken |=> (imemAddr == $past(exPc4) + {$past(exImm[XLEN-3:0]), 2'b00}));

  a_r5_bne_redirect: assert property (@(posedge clk) disable iff (rst)
    bneTaken |=> (imemAddr == $past(exPc4) + {$past(exImm[XLEN-3:0]), 2'b00}));

  a_r5_two_bubbles: assert property (@(posedge clk) disable iff (rst)
    (beqTaken || bneTaken) |=> !exValid ##1 !exValid);

  a_r4_jump_target: assert property (@(posedge clk) disable iff (rst)
    (exValid && op == OP_JUMP) |->
      (imemAddr == {exPc4[XLEN-1 -: PCHI_W], exInstr[JIDX_W-1:0], 2'b00}));

  a_r7_store_enables: assert property (@(posedge clk) disable iff (rst)
    (exValid && op == OP_STORE) |-> (exMemWrite && !exRegWrite));

  a_r3_imm_sign: assert property (@(posedge clk) disable iff (rst)
    exValid |-> (exImm == {{(XLEN-IMM_W){exInstr[IMM_W-1]}}, exInstr[IMM_W-1:0]}));
endmodule

bind fetch_front fetch_front_chk #(.RESET_VEC(RESET_VEC)) u_chk (.*);

// File: tb/sim_fetch_front.sv
`timescale 1ns/1ps
module sim_fetch_front;
  localparam logic [31:0] BASE = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        brZero = 1'b0;
  logic [31:0] imemAddr, imemData, exPc4, exInstr, exImm;
  logic        exValid, exRegWrite, exMemWrite;
  logic [31:0] prog [64];

  int checks = 0;
  int fails  = 0;

  // bench reference state
  logic [31:0] mPc, mIfPc4, mIfIns, mExPc4, mExIns, mExImm;
  logic        mIfV, mExV, mExRw, mExMw;
  string       pcTag;

  always #5 clk = ~clk;

  assign imemData = prog[imemAddr[7:2]];

  fetch_front #(.RESET_VEC(BASE)) u0 (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .brZero(brZero), .exValid(exValid), .exPc4(exPc4), .exInstr(exInstr),
    .exImm(exImm), .exRegWrite(exRegWrite), .exMemWrite(exMemWrite)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] opOf(logic [31:0] w);
    return w[31:26];
  endfunction

  function automatic logic [31:0] sext(logic [31:0] w);
    return {{16{w[15]}}, w[15:0]};
  endfunction

  function automatic logic [31:0] mkBranch(logic [5:0] op, int off);
    logic [31:0] o = off;
    return {op, 5'd1, 5'd2, o[15:0]};
  endfunction

  function automatic logic [31:0] mkJump(logic [31:0] target);
    return {6'b000010, target[27:2]};
  endfunction

  function automatic logic [31:0] randWord();
    int k = $urandom_range(7, 0);
    case (k)
      2:       return {6'b100011, 26'($urandom)};
      3:       return {6'b101011, 26'($urandom)};
      4:       return mkBranch(6'b000100, $urandom_range(12, 0) - 6);
      5:       return mkBranch(6'b000101, $urandom_range(12, 0) - 6);
      6:       return mkJump(BASE + 32'($urandom_range(63, 0)) * 4);
      7:       return {6'b001000, 26'($urandom)};
      default: return {6'b000000, 26'($urandom)};
    endcase
  endfunction

  task automatic modelReset();
    mPc = BASE; mIfV = 0; mIfPc4 = 0; mIfIns = 0;
    mExV = 0; mExPc4 = 0; mExIns = 0; mExImm = 0; mExRw = 0; mExMw = 0;
    pcTag = "R1";
  endtask

  task automatic modelStep();
    logic exBr, taken, idJ;
    logic [31:0] bt, jt;
    exBr  = mExV && (opOf(mExIns) == 6'b000100 || opOf(mExIns) == 6'b000101);
    taken = exBr && ((opOf(mExIns) == 6'b000101) ? !brZero : brZero);
    idJ   = mIfV && opOf(mIfIns) == 6'b000010;
    bt    = mExPc4 + (mExImm << 2);
    jt    = {mIfPc4[31:28], mIfIns[25:0], 2'b00};
    if (taken)    pcTag = idJ ? "R8" : "R5";
    else if (idJ) pcTag = "R4";
    else          pcTag = (brZero && !exBr) ? "R9" : "R2";
    if (taken || !mIfV) begin
      mExV = 0; mExPc4 = 0; mExIns = 0; mExImm = 0; mExRw = 0; mExMw = 0;
    end else begin
      mExV = 1; mExPc4 = mIfPc4; mExIns = mIfIns; mExImm = sext(mIfIns);
      mExRw = (opOf(mIfIns) == 6'b000000) || (opOf(mIfIns) == 6'b100011);
      mExMw = (opOf(mIfIns) == 6'b101011);
    end
    if (taken || idJ) begin
      mIfV = 0; mIfPc4 = 0; mIfIns = 0;
    end else begin
      mIfV = 1; mIfPc4 = mPc + 4; mIfIns = prog[mPc[7:2]];
    end
    mPc = taken ? bt : (idJ ? jt : mPc + 4);
  endtask

  task automatic compareAll();
    chk(pcTag, imemAddr, mPc);
    chk("R6 valid", {31'd0, exValid}, {31'd0, mExV});
    chk("R7 regWrite", {31'd0, exRegWrite}, {31'd0, mExRw});
    chk("R7 memWrite", {31'd0, exMemWrite}, {31'd0, mExMw});
    if (mExV) begin
      chk("R2 pc4", exPc4, mExPc4);
      chk("R2 instr", exInstr, mExIns);
      chk("R3 imm", exImm, mExImm);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    modelReset();
    chk("R1 addr", imemAddr, BASE);
    chk("R1 valid", {31'd0, exValid}, 32'd0);
    chk("R6 enables", {30'd0, exRegWrite, exMemWrite}, 32'd0);
    rst = 1'b0;
  endtask

  // zeroMode: 0 random, 1 forced high, 2 forced low
  task automatic runCycles(int n, int zeroMode);
    for (int c = 0; c < n; c++) begin
      compareAll();
      brZero = (zeroMode == 0) ? 1'($urandom) : (zeroMode == 1);
      modelStep();
      @(negedge clk);
    end
  endtask

  task automatic fillFiller();
    for (int i = 0; i < 64; i++) prog[i] = {6'b000000, 26'(i)};
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed: beq (imm 8) followed by a jump in the next slot
    fillFiller();
    prog[0] = mkBranch(6'b000100, 8);
    prog[1] = mkJump(BASE + 32'h40);
    doReset();
    runCycles(3, 1);
    chk("R8 branch beats jump", imemAddr, BASE + 32'h24);
    runCycles(8, 1);
    doReset();
    runCycles(3, 2);
    chk("R4 jump after untaken beq", imemAddr, BASE + 32'h40);
    runCycles(8, 2);
    // directed: bne with negative offset -2
    fillFiller();
    prog[0] = mkBranch(6'b000101, -2);
    prog[2] = {6'b101011, 26'h5};
    doReset();
    runCycles(3, 2);
    chk("R5 bne negative target", imemAddr, 32'h003F_FFFC);
    // directed: store reaching EX, brZero toggled with no branch present
    fillFiller();
    prog[1] = {6'b101011, 26'h3};
    doReset();
    runCycles(3, 1);
    chk("R7 store memWrite", {30'd0, exRegWrite, exMemWrite}, 32'd1);
    chk("R9 flag ignored", imemAddr, BASE + 32'h0C);
    // random programs
    for (int p = 0; p < 10; p++) begin
      for (int i = 0; i < 64; i++) prog[i] = randWord();
      doReset();
      runCycles(400, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule